// File: doc/BRIEF.md
# PHY Calibration Write Sequencer

This block tunes a USB 3.0 PHY after the host controller has come up. A single start pulse launches three ordered writes through a control-register port master. The first write programs the loss-of-signal detector override. The second raises the transmit voltage boost level. The third sets the receiver-detect measurement time, and its value is chosen from the reference-clock frequency code. System logic pulses start again each time the port enters host mode, and the sequence then reruns from the first write.

Each write is offered to the port master as a held request with an address and a data word. The master answers with a one-cycle completion or a one-cycle error. The first error ends the sequence at once, and the writes not yet issued are skipped. The block reports the outcome as a one-cycle done pulse or a one-cycle error pulse, and it holds busy high while a sequence runs.

Top module: `phy_cal_seq`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o, error_o and wr_req_o are all low until a start is accepted.
- R2: A start_i pulse that is sampled while idle makes busy_o and wr_req_o high from the next cycle on, with the first write at address 0x0015 carrying data 0xA409 (bias 5 in bits 15:13, override enable in bit 10, level 9 in bits 3:0).
- R3: After the first write completes, wr_req_o is low for exactly one cycle and then the second write is offered at address 0x0012 with data 0xA000 (boost 5 in bits 15:13).
- R4: The third write goes to address 0x1010 with a measurement-time field in bits 10:4 and zeros elsewhere. The field is 0x04 for refclk_sel code 0 (19.2 MHz) or code 1 (20 MHz), 0x20 for code 3 (50 MHz), and 0x08 for code 2 (24 MHz) and for codes 4 to 7.
- R5: refclk_sel_i is captured when start is accepted, and later changes to it have no effect on the third write.
- R6: While wr_req_o is high and neither wr_done_i nor wr_err_i is high, wr_req_o, wr_addr_o and wr_data_o hold their values into the next cycle.
- R7: wr_err_i sampled during a write ends the sequence. In the next cycle error_o is high for one cycle, busy_o and wr_req_o are low, and no further write is offered. wr_err_i takes priority over a wr_done_i in the same cycle.
- R8: The cycle after the third write's wr_done_i, done_o is high for one cycle and busy_o is low. done_o never rises earlier in a sequence or after an error.
- R9: A start_i pulse that arrives while busy_o is high is ignored and does not change the write series.
- R10: After done or error, a new start runs the complete sequence again from the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Calibration start pulse |
| refclk_sel_i | input | 3 | Reference-clock frequency code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: all writes succeeded |
| error_o | output | 1 | One-cycle pulse: a write failed |
| wr_req_o | output | 1 | Write request to the port master, held until answered |
| wr_addr_o | output | 16 | Target register address of the write |
| wr_data_o | output | 16 | Data word of the write |
| wr_done_i | input | 1 | Port master: write completed |
| wr_err_i | input | 1 | Port master: write failed |

## Verification
Reset is released through a two-stage synchronizer, so the bench waits several cycles after release before it issues any stimulus. Busy and the first request appear one edge after start is sampled, and the next request appears two edges after a completion, following a one-cycle gap. done_o or error_o appears one edge after the final answer. The bench drives every input at the falling edge and checks at the following falling edge, so exactly one rising edge separates each stimulus from the result it checks. The port-master model answers after a random delay of zero to three cycles. During that delay the bench rechecks the held request and fires stray start pulses.

// File: rtl/phy_cal_pkg.sv
package phy_cal_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int SEL_W   = 3;
  localparam int MEAS_W  = 7;
  localparam int MEAS_LSB = 4;
  localparam int N_WRITES = 3;
  localparam int STEP_W  = $clog2(N_WRITES);

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_ISSUE = 2'd1,
    CS_GAP   = 2'd2
  } cal_state_e;

  // Reference-clock frequency codes
  localparam logic [SEL_W-1:0] RC_19M2 = 3'd0;
  localparam logic [SEL_W-1:0] RC_20M  = 3'd1;
  localparam logic [SEL_W-1:0] RC_24M  = 3'd2;
  localparam logic [SEL_W-1:0] RC_50M  = 3'd3;

  // Measurement-time field values
  localparam logic [MEAS_W-1:0] MT_LOW  = 7'h04;
  localparam logic [MEAS_W-1:0] MT_MID  = 7'h08;
  localparam logic [MEAS_W-1:0] MT_HIGH = 7'h20;

  // Target addresses, in issue order
  localparam logic [ADDR_W-1:0] A_LOSOVR = 16'h0015;
  localparam logic [ADDR_W-1:0] A_BOOST  = 16'h0012;
  localparam logic [ADDR_W-1:0] A_RXDET  = 16'h1010;

  // Data words assembled from their fields
  localparam logic [DATA_W-1:0] D_LOSOVR = (16'd5 << 13) | (16'd1 << 10) | 16'd9;
  localparam logic [DATA_W-1:0] D_BOOST  = (16'd5 << 13);
endpackage

// File: rtl/phy_cal_decode.sv
module phy_cal_decode
  import phy_cal_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  output logic [MEAS_W-1:0] meas_o
);
  always_comb begin
    unique case (sel_i)
      RC_19M2, RC_20M: meas_o = MT_LOW;
      RC_50M:          meas_o = MT_HIGH;
      default:         meas_o = MT_MID;
    endcase
  end
endmodule

// File: rtl/phy_cal_words.sv
module phy_cal_words
  import phy_cal_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  input  logic [MEAS_W-1:0] meas_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] rxdet_word;

  always_comb begin
    rxdet_word = '0;
    rxdet_word[MEAS_LSB +: MEAS_W] = meas_i;
  end

  always_comb begin
    unique case (step_i)
      STEP_W'(0): begin addr_o = A_LOSOVR; data_o = D_LOSOVR;   end
      STEP_W'(1): begin addr_o = A_BOOST;  data_o = D_BOOST;    end
      default:    begin addr_o = A_RXDET;  data_o = rxdet_word; end
    endcase
  end
endmodule

// File: rtl/phy_cal_fsm.sv
module phy_cal_fsm
  import phy_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wr_done_i,
  input  logic              wr_err_i,
  output logic [STEP_W-1:0] step_o,
  output logic [SEL_W-1:0]  sel_q_o,
  output logic              busy_o,
  output logic              req_o,
  output logic              done_o,
  output logic              error_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_WRITES - 1);

  cal_state_e        st_q, st_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [SEL_W-1:0]  sel_q, sel_n;
  logic              done_q, done_n, err_q, err_n;
  logic              sel_en;

  always_comb begin
    st_n   = st_q;
    step_n = step_q;
    sel_en = 1'b0;
    done_n = 1'b0;
    err_n  = 1'b0;
    unique case (st_q)
      CS_IDLE: if (start_i) begin
        st_n   = CS_ISSUE;
        step_n = '0;
        sel_en = 1'b1;
      end
      CS_ISSUE: begin
        if (wr_err_i) begin
          st_n  = CS_IDLE;
          err_n = 1'b1;
        end else if (wr_done_i) begin
          if (step_q == LAST_STEP) begin
            st_n   = CS_IDLE;
            done_n = 1'b1;
          end else begin
            st_n   = CS_GAP;
            step_n = step_q + STEP_W'(1);
          end
        end
      end
      default: st_n = CS_ISSUE;
    endcase
    sel_n = sel_en ? sel_i : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CS_IDLE;
      step_q <= '0;
      sel_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      step_q <= step_n;
      sel_q  <= sel_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  assign step_o  = step_q;
  assign sel_q_o = sel_q;
  assign busy_o  = (st_q != CS_IDLE);
  assign req_o   = (st_q == CS_ISSUE);
  assign done_o  = done_q;
  assign error_o = err_q;

  p_start_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && req_o && step_o == '0));
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !wr_done_i && !wr_err_i) |=> (req_o && $stable(step_o)));
  p_err_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && wr_err_i) |=> (error_o && !busy_o && !req_o));
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> !error_o);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(sel_q_o));
endmodule

// File: rtl/phy_cal_seq.sv
module phy_cal_seq
  import phy_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        refclk_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              wr_req_o,
  output logic [15:0]       wr_addr_o,
  output logic [15:0]       wr_data_o,
  input  logic              wr_done_i,
  input  logic              wr_err_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [STEP_W-1:0] step;
  logic [SEL_W-1:0]  sel_q;
  logic [MEAS_W-1:0] meas;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  phy_cal_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .sel_i     (refclk_sel_i),
    .wr_done_i (wr_done_i),
    .wr_err_i  (wr_err_i),
    .step_o    (step),
    .sel_q_o   (sel_q),
    .busy_o    (busy_o),
    .req_o     (wr_req_o),
    .done_o    (done_o),
    .error_o   (error_o)
  );

  phy_cal_decode u_dec (
    .sel_i  (sel_q),
    .meas_o (meas)
  );

  phy_cal_words u_words (
    .step_i (step),
    .meas_i (meas),
    .addr_o (wr_addr_o),
    .data_o (wr_data_o)
  );

  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_req_o && !wr_done_i && !wr_err_i) |=> ($stable(wr_addr_o) && $stable(wr_data_o)));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> !wr_req_o);
endmodule

// File: tb/tb_phy_cal_seq.sv
`timescale 1ns/1ps
module tb_phy_cal_seq;
  logic        clk, rst_n, start, wr_done, wr_err;
  logic [2:0]  sel;
  logic        busy, done, error, wr_req;
  logic [15:0] wr_addr, wr_data;
  int total = 0, bad = 0;
  bit finished = 0;

  phy_cal_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .refclk_sel_i(sel),
    .busy_o(busy), .done_o(done), .error_o(error), .wr_req_o(wr_req),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_done_i(wr_done), .wr_err_i(wr_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] exp_addr(int step);
    case (step)
      0: return 16'h0015;
      1: return 16'h0012;
      default: return 16'h1010;
    endcase
  endfunction

  function automatic logic [15:0] exp_data(int step, logic [2:0] code);
    logic [15:0] f;
    case (step)
      0: return 16'hA409;
      1: return 16'hA000;
      default: begin
        case (code)
          3'd0, 3'd1: f = 16'h04;
          3'd3:       f = 16'h20;
          default:    f = 16'h08;
        endcase
        return f << 4;
      end
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // fail_at: index of the write that reports an error, 3 = none
  task automatic run_cal(logic [2:0] code, int fail_at, bit jam);
    @(negedge clk);
    start = 1'b1; sel = code;
    @(negedge clk);
    start = 1'b0; sel = 3'($urandom);                 // R5: later code ignored
    chk("R2 busy after start", {31'd0, busy}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      int lat = $urandom_range(0, 3);
      chk(i == 0 ? "R2 first req" : "R3 req after gap", {31'd0, wr_req}, 32'd1);
      chk(i == 2 ? "R4 R5 addr" : "R2 R3 addr", {16'd0, wr_addr}, {16'd0, exp_addr(i)});
      chk(i == 2 ? "R4 R5 data" : "R2 R3 data", {16'd0, wr_data}, {16'd0, exp_data(i, code)});
      for (int w = 0; w < lat; w++) begin
        start = jam ? 1'($urandom) : 1'b0;           // R9: stray starts
        @(negedge clk);
        chk("R6 R9 req held", {31'd0, wr_req}, 32'd1);
        chk("R6 R9 data held", {16'd0, wr_data}, {16'd0, exp_data(i, code)});
      end
      start = 1'b0;
      if (i == fail_at) begin
        wr_err = 1'b1; wr_done = ($urandom_range(0, 1) == 1); // R7: err wins
        @(negedge clk);
        wr_err = 1'b0; wr_done = 1'b0;
        chk("R7 error pulse", {29'd0, error, busy, wr_req}, 32'b100);
        chk("R8 no done on error", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk("R7 quiet after error", {28'd0, error, done, busy, wr_req}, 32'd0);
        return;
      end
      wr_done = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
      if (i < 2) begin
        chk("R3 gap cycle", {29'd0, busy, wr_req, done}, 32'b100);
        @(negedge clk);
      end else begin
        chk("R8 done pulse", {29'd0, done, busy, error}, 32'b100);
        @(negedge clk);
        chk("R8 done one cycle", {29'd0, done, busy, wr_req}, 32'd0);
      end
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; sel = 3'd0; wr_done = 1'b0; wr_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, busy, done, error, wr_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {28'd0, busy, done, error, wr_req}, 32'd0);
    for (int c = 0; c < 8; c++) run_cal(3'(c), 3, 1'b0);   // R4 every code
    run_cal(3'd2, 0, 1'b1);                                 // R7 each position
    run_cal(3'd3, 1, 1'b1);
    run_cal(3'd0, 2, 1'b1);
    run_cal(3'd3, 3, 1'b1);                                 // R10 rerun after error
    n = 0;
    while (n < 40) begin
      run_cal(3'($urandom), $urandom_range(0, 5), 1'b1);
      n++;
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule